// File: doc/BRIEF.md
# Pulse-Width Bit Discriminator

This block turns a demodulated, amplitude-keyed carrier into data symbols. A strobe marks each carrier cycle, and ten cycles make one baud. On each strobe the block takes two values. The first is the raw envelope amplitude of the cycle, which is compared with an adaptive slice level. The second is an integrated (averaged) envelope, which is compared with the midpoint of the current signal and noise estimates. It does not generate or filter the envelope.

The integrated decisions go into a long history register. When a fixed framing signature shows up there, the cycle counter is pulled back to the baud boundary. If the counter was not already about to reach that boundary, the block reports a sync error.

At every baud boundary the block reads the lowest eight raw decisions and classifies the baud from the length of its leading run of high cycles. The result is a zero, a one or a position identifier. Any other pattern is delivered as a zero together with a decode error. The slice level for the next baud is then set halfway between the envelope peak seen early in the baud and the envelope trough seen at its end.

Top module: `pulse_width_discriminator`

## Requirements
- R1: Reset behaviour:
  - After reset, `sym_vld`, `sync_err`, `dec_err` and `sym` are 0.
  - The slice level starts at 0.
  - The cycle counter starts at 0, so without a framing hit the first symbol follows the tenth strobe.
- R2: Cycle counter and symbol timing:
  - The cycle counter advances modulo 10 on each strobe.
  - On the strobe whose advanced count is 0, `sym_vld` is high for exactly one clock, in the cycle after that strobe's edge.
- R3: Integrated decision:
  - On each strobe, `integ >= floor((sig_lvl + noise_lvl)/2)` (signed arithmetic) gives a decision bit.
  - The bit is shifted in at bit 0 of a 32-bit history register.
- R4: Framing realignment:
  - When `(history & 0x303C0F03) == 0x300C0300` after the shift, the advanced count is forced to 0, so a symbol is emitted on that strobe.
  - `sync_err` pulses in the same cycle as `sym_vld` if the advanced count would not have been 0.
- R5: Raw decision:
  - On each strobe, `env >= slice` (signed, using the slice level in force before the strobe) is shifted in at bit 0 of a 10-bit raw register.
- R6: Symbol classification on the low 8 raw bits, where bit 0 is the newest cycle:
  - 0x00 or 0x80 gives a zero, encoded 2'b00.
  - 0xC0, 0xE0 or 0xF0 gives a one, encoded 2'b01.
  - 0xF8, 0xFC or 0xFE gives a position identifier, encoded 2'b10.
- R7: Decode error:
  - Any other low byte gives `sym` = 2'b00 with `dec_err` high for the same single clock as `sym_vld`.
- R8: Slice-level update:
  - The envelope maximum is loaded at advanced count 1 and raised at count 2.
  - The envelope minimum is loaded at count 9 and lowered at count 0.
  - At count 0 the new slice level becomes `floor((max + min)/2)`, with the minimum including the count-0 envelope.
- R9: Clocks without a strobe change no state and never raise `sym_vld`, `sync_err` or `dec_err`, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-clock strobe per carrier cycle |
| env | input | 16 | Raw envelope amplitude, signed |
| integ | input | 16 | Integrated envelope amplitude, signed |
| sig_lvl | input | 16 | Signal amplitude estimate, signed |
| noise_lvl | input | 16 | Noise amplitude estimate, signed |
| sym | output | 2 | Symbol: 00 zero, 01 one, 10 position identifier |
| sym_vld | output | 1 | One-clock symbol valid |
| sync_err | output | 1 | Framing realigned a misaligned counter |
| dec_err | output | 1 | Baud pattern not a legal pulse width |

## Verification
The hardest condition to reach from the ports is a framing slip. The integrated decisions must form the 30-cycle signature exactly, and at a phase that disagrees with the running counter. The stimulus produces this with a periodic integrated pattern of two high cycles every ten cycles, shifted by a chosen offset. It sets the high value exactly at the floored threshold and the low value one below it, with odd signal-plus-noise sums of both signs. It then moves the offset again, and finally drops the high value one step below threshold so that no hit may occur. A sweep of all 1024 ten-cycle raw patterns with varying amplitudes drives the slice level through collapsed and unbalanced states, which makes decode errors appear for reasons the pattern alone would not predict.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_MARK = 2'b10
    } sym_e;

    typedef struct packed {
        sym_e sym;
        logic bad;
    } cls_t;

    // run-length class boundaries (count of leading high cycles)
    localparam int ONE_MIN_RUN  = 2;
    localparam int MARK_MIN_RUN = 5;

    // a legal baud is a thermometer of ones from the oldest end, shorter than the window
    function automatic cls_t classify_run(input logic [7:0] run);
        cls_t r;
        int   ones;
        logic [7:0] thermo;
        ones   = $countones(run);
        thermo = ~(8'hFF >> ones);
        r.sym  = SYM_ZERO;
        r.bad  = 1'b1;
        if (ones < 8 && run == thermo) begin
            r.bad = 1'b0;
            if (ones >= MARK_MIN_RUN)     r.sym = SYM_MARK;
            else if (ones >= ONE_MIN_RUN) r.sym = SYM_ONE;
            else                          r.sym = SYM_ZERO;
        end
        return r;
    endfunction

endpackage

// File: rtl/pd_framer.sv
module pd_framer #(
    parameter int W    = 16,
    parameter int CYC  = 10,
    parameter int FW   = 32,
    parameter logic [FW-1:0] MASK = FW'(32'h303C0F03),
    parameter logic [FW-1:0] PAT  = FW'(32'h300C0300),
    localparam int CW  = $clog2(CYC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic signed [W-1:0] integ,
    input  logic signed [W-1:0] sig_lvl,
    input  logic signed [W-1:0] noise_lvl,
    output logic [CW-1:0]       phase_nx,
    output logic                slip
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [FW-1:0] hist;
    } fr_t;

    fr_t s_d, s_q;

    logic signed [W:0] lvl_sum;
    logic signed [W:0] thr;
    logic signed [W:0] integ_x;
    logic              above;
    logic [CW-1:0]     adv;
    logic [FW-1:0]     hist_nx;
    logic              hit;

    always_comb begin
        s_d      = s_q;
        slip     = 1'b0;
        phase_nx = s_q.cnt;

        lvl_sum  = {sig_lvl[W-1], sig_lvl} + {noise_lvl[W-1], noise_lvl};
        thr      = lvl_sum >>> 1;
        integ_x  = {integ[W-1], integ};
        above    = (integ_x >= thr);
        adv      = (s_q.cnt == CW'(CYC - 1)) ? '0 : s_q.cnt + 1'b1;
        hist_nx  = {s_q.hist[FW-2:0], above};
        hit      = ((hist_nx & MASK) == PAT);

        if (stb) begin
            s_d.hist = hist_nx;
            if (hit) begin
                slip = (adv != '0);
                adv  = '0;
            end
            s_d.cnt  = adv;
            phase_nx = adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pd_slicer.sv
module pd_slicer #(
    parameter int W   = 16,
    parameter int CYC = 10,
    parameter int RW  = 10,
    localparam int CW = $clog2(CYC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic signed [W-1:0] env,
    input  logic [CW-1:0]       phase_nx,
    output logic [RW-1:0]       run_nx
);

    localparam logic [CW-1:0] PH_END    = '0;
    localparam logic [CW-1:0] PH_MAX_LD = CW'(1);
    localparam logic [CW-1:0] PH_MAX_UP = CW'(2);
    localparam logic [CW-1:0] PH_MIN_LD = CW'(CYC - 1);

    typedef struct packed {
        logic [RW-1:0]       run;
        logic signed [W-1:0] emax;
        logic signed [W-1:0] emin;
        logic signed [W-1:0] slice;
    } sl_t;

    sl_t s_d, s_q;

    logic signed [W-1:0] lo;
    logic signed [W:0]   mid_sum;

    always_comb begin
        s_d     = s_q;
        run_nx  = {s_q.run[RW-2:0], (env >= s_q.slice)};
        lo      = (env < s_q.emin) ? env : s_q.emin;
        mid_sum = {s_q.emax[W-1], s_q.emax} + {lo[W-1], lo};

        if (stb) begin
            s_d.run = run_nx;
            if (phase_nx == PH_END) begin
                s_d.emin  = lo;
                s_d.slice = mid_sum[W:1];
            end else if (phase_nx == PH_MAX_LD) begin
                s_d.emax = env;
            end else if (phase_nx == PH_MAX_UP) begin
                if (env > s_q.emax) s_d.emax = env;
            end else if (phase_nx == PH_MIN_LD) begin
                s_d.emin = env;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pd_classify.sv
module pd_classify
    import pd_pkg::*;
#(
    parameter int RW = 10
) (
    input  logic [RW-1:0] run,
    output sym_e          sym,
    output logic          bad
);

    cls_t c;

    always_comb begin
        c   = classify_run(run[7:0]);
        sym = c.sym;
        bad = c.bad;
    end

endmodule

// File: rtl/pulse_width_discriminator.sv
module pulse_width_discriminator
    import pd_pkg::*;
#(
    parameter int W   = 16,
    parameter int CYC = 10,
    parameter int FW  = 32,
    parameter int RW  = 10,
    localparam int CW = $clog2(CYC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_stb,
    input  logic signed [W-1:0] env,
    input  logic signed [W-1:0] integ,
    input  logic signed [W-1:0] sig_lvl,
    input  logic signed [W-1:0] noise_lvl,
    output logic [1:0]          sym,
    output logic                sym_vld,
    output logic                sync_err,
    output logic                dec_err
);

    typedef struct packed {
        sym_e sym;
        logic vld;
        logic sync_err;
        logic dec_err;
    } out_t;

    out_t o_d, o_q;

    logic [CW-1:0] phase_nx;
    logic          slip;
    logic [RW-1:0] run_nx;
    sym_e          cls_sym;
    logic          cls_bad;

    pd_framer #(.W(W), .CYC(CYC), .FW(FW)) i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (cyc_stb),
        .integ     (integ),
        .sig_lvl   (sig_lvl),
        .noise_lvl (noise_lvl),
        .phase_nx  (phase_nx),
        .slip      (slip)
    );

    pd_slicer #(.W(W), .CYC(CYC), .RW(RW)) i_slicer (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (cyc_stb),
        .env      (env),
        .phase_nx (phase_nx),
        .run_nx   (run_nx)
    );

    pd_classify #(.RW(RW)) i_classify (
        .run (run_nx),
        .sym (cls_sym),
        .bad (cls_bad)
    );

    always_comb begin
        o_d          = o_q;
        o_d.vld      = 1'b0;
        o_d.sync_err = 1'b0;
        o_d.dec_err  = 1'b0;
        if (cyc_stb && phase_nx == '0) begin
            o_d.vld      = 1'b1;
            o_d.sym      = cls_sym;
            o_d.dec_err  = cls_bad;
            o_d.sync_err = slip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '{sym: SYM_ZERO, vld: 1'b0, sync_err: 1'b0, dec_err: 1'b0};
        else        o_q <= o_d;
    end

    assign sym      = o_q.sym;
    assign sym_vld  = o_q.vld;
    assign sync_err = o_q.sync_err;
    assign dec_err  = o_q.dec_err;

endmodule

// File: rtl/pd_checks.sv
module pd_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_stb,
    input logic [1:0] sym,
    input logic       sym_vld,
    input logic       sync_err,
    input logic       dec_err
);

    // R9: a symbol pulse only follows a strobe edge
    p_vld_needs_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> $past(cyc_stb))
        else $error("sym_vld without preceding strobe");

    // R2: valid lasts a single clock
    p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |=> !sym_vld)
        else $error("sym_vld held longer than one clock");

    // R4: a slip always coincides with an emitted symbol
    p_slip_with_sym_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> sym_vld)
        else $error("sync_err without symbol");

    // R7: decode error comes with a zero symbol
    p_bad_is_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (sym_vld && sym == 2'b00))
        else $error("dec_err without zero symbol");

    // R6: the unused code never appears
    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> (sym != 2'b11))
        else $error("illegal symbol code");

endmodule

bind pulse_width_discriminator pd_checks i_pd_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_stb  (cyc_stb),
    .sym      (sym),
    .sym_vld  (sym_vld),
    .sync_err (sync_err),
    .dec_err  (dec_err)
);

// File: tb/test_pulse_width_discriminator.sv
`timescale 1ns/1ps
module test_pulse_width_discriminator;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cyc_stb = 1'b0;
    logic signed [15:0] env = '0;
    logic signed [15:0] integ = '0;
    logic signed [15:0] sig_lvl = '0;
    logic signed [15:0] noise_lvl = '0;
    logic [1:0]         sym;
    logic               sym_vld;
    logic               sync_err;
    logic               dec_err;

    always #2.5 clk = ~clk;

    pulse_width_discriminator i_pulse_width_discriminator (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .env(env), .integ(integ),
        .sig_lvl(sig_lvl), .noise_lvl(noise_lvl),
        .sym(sym), .sym_vld(sym_vld), .sync_err(sync_err), .dec_err(dec_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int unsigned seed = 32'h1234_5678;

    // reference state, derived from the requirements
    int       m_cnt = 0;
    bit [31:0] m_hist = '0;
    bit [9:0] m_run = '0;
    int       m_max = 0, m_min = 0, m_slice = 0;
    int       n_slips = 0;

    function automatic int rnd(input int span);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % span);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // one strobe, then gap idle clocks with junk data
    task automatic strobe(input int e, input int ig, input int sg, input int nz, input int gap);
        int adv, thr, lo;
        bit hit, e_sync, e_vld, e_dec;
        int e_sym;
        // R3 / R4 reference
        adv = (m_cnt + 1) % 10;
        thr = (sg + nz) >>> 1;
        m_hist = {m_hist[30:0], (ig >= thr)};
        hit = ((m_hist & 32'h303C0F03) == 32'h300C0300);
        e_sync = 0;
        if (hit) begin
            e_sync = (adv != 0);
            adv = 0;
        end
        // R5 reference
        m_run = {m_run[8:0], (e >= m_slice)};
        e_vld = (adv == 0);
        e_sym = 0; e_dec = 0;
        if (e_vld) begin
            case (m_run[7:0])
                8'h00, 8'h80:        e_sym = 0;
                8'hC0, 8'hE0, 8'hF0: e_sym = 1;
                8'hF8, 8'hFC, 8'hFE: e_sym = 2;
                default: begin e_sym = 0; e_dec = 1; end
            endcase
            lo = (e < m_min) ? e : m_min;
            m_min = lo;
            m_slice = (m_max + lo) >>> 1;
        end else if (adv == 1) m_max = e;
        else if (adv == 2) begin if (e > m_max) m_max = e; end
        else if (adv == 9) m_min = e;
        m_cnt = adv;
        if (e_sync) n_slips++;

        env = 16'(e); integ = 16'(ig); sig_lvl = 16'(sg); noise_lvl = 16'(nz);
        cyc_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        cyc_stb = 1'b0;
        chk(sym_vld == e_vld, "R2 sym_vld", int'(sym_vld), int'(e_vld));
        chk(sync_err == e_sync, "R4 sync_err", int'(sync_err), int'(e_sync));
        chk(dec_err == e_dec, "R7 dec_err", int'(dec_err), int'(e_dec));
        if (e_vld)
            chk(int'(sym) == e_sym, e_dec ? "R7 sym" : "R6 sym", int'(sym), e_sym);
        for (int g = 0; g < gap; g++) begin
            env = 16'(rnd(65536)); integ = 16'(rnd(65536));
            sig_lvl = 16'(rnd(65536)); noise_lvl = 16'(rnd(65536));
            @(posedge clk); @(negedge clk);
            chk(!sym_vld && !sync_err && !dec_err, "R9 idle pulses",
                int'({sym_vld, sync_err, dec_err}), 0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            summary();
        end
    end

    initial begin
        int hi, lo, thr, base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!sym_vld && !sync_err && !dec_err && sym == 2'b00, "R1 reset outputs",
            int'({sym, sym_vld, sync_err, dec_err}), 0);

        // R5 R6 R7 R8: all ten-cycle raw patterns, framing kept idle
        for (int p = 0; p < 1024; p++) begin
            hi = 400 + (p % 37) * 10;
            lo = -(300 + (p % 23) * 10);
            for (int k = 0; k < 10; k++)
                strobe(p[9-k] ? hi : lo, -20000, 100, 100, (p % 3 == 0 && k == 4) ? 1 : 0);
        end

        // R3 R4: framing pattern at exact threshold, odd sums of both signs
        base = n_slips;
        thr = (7 + (-2)) >>> 1;
        for (int t = 0; t < 60; t++)
            strobe(500, (((t + 3) % 10) == 1 || ((t + 3) % 10) == 2) ? thr : thr - 1, 7, -2, 0);
        chk(n_slips > base, "R4 slip seen", n_slips - base, 1);
        thr = (-7 + 2) >>> 1;
        for (int t = 0; t < 60; t++)
            strobe(-500, (((t + 7) % 10) == 1 || ((t + 7) % 10) == 2) ? thr : thr - 1, -7, 2, t % 2);
        // R3: high value one below threshold never frames
        base = n_slips;
        for (int t = 0; t < 60; t++)
            strobe(300, thr - 1, -7, 2, 0);
        chk(n_slips == base, "R3 no slip below threshold", n_slips - base, 0);

        // mixed pseudo-random traffic
        for (int t = 0; t < 3000; t++)
            strobe(rnd(4000) - 2000, rnd(400) - 200, rnd(200) - 100, rnd(200) - 100, rnd(3));

        summary();
    end

endmodule